// File: doc/BRIEF.md
# Call and Stack Sequencer

This block carries out the memory side of the stack and control-transfer operations of a small 8-bit processor with a 16-bit stack pointer and a 16-bit program counter. It can push a register pair, pop a register pair, call an absolute target, restart at one of eight fixed low addresses, and return. Call and return may depend on a condition drawn from the zero and carry flags.

A caller presents the operation, the current stack pointer and program counter, the pair value, the target and the vector index, all on one start cycle. The operand bytes of a call are taken as already fetched, so the block only spends their cycles. The block then drives a byte-wide memory port, with at most one access in each machine cycle (one clock). When the operation ends it raises a one-cycle completion pulse. With that pulse it presents the new stack pointer, the new program counter, the popped pair, a taken indication and the number of machine cycles used. These results stay unchanged until the next operation completes.

Top module: `stack_call_seq`

## Requirements
- R1: After reset, busy, done, mem_we and mem_re are low, and sp_out, pc_out, pair_out and cycles_used are zero.
- R2: Push (op 0) takes 4 cycles. In cycle 3 it writes the high byte of the pair to SP-1. In cycle 4 it writes the low byte to SP-2. The result is SP-2 and PC+1.
- R3: Pop (op 1) takes 3 cycles. In cycle 2 it reads the low byte from SP. In cycle 3 it reads the high byte from SP+1. The result is SP+2 and PC+1, and pair_out holds {high, low}.
- R4: When pair_is_flags is high, bits 3..0 of the low byte are forced to zero, both in the byte a push writes and in the pair a pop returns.
- R5: Call (op 2), when taken, takes 6 cycles. It writes PC+3 like a push in cycles 5 and 6, then sets PC to target_in and SP to SP-2. When its condition fails, it takes 3 cycles, makes no memory access, sets PC to PC+3 and leaves SP unchanged.
- R6: Restart (op 3) takes 4 cycles. It writes PC+1 like a push in cycles 3 and 4, then sets PC to vec_idx*8 and SP to SP-2.
- R7: An unconditional return (op 4) takes 4 cycles and reads the low byte of PC from SP in cycle 2 and the high byte from SP+1 in cycle 3. A conditional return that is taken takes 5 cycles, with the reads in cycles 3 and 4. In both taken cases SP becomes SP+2. An untaken return takes 2 cycles, makes no access, and sets PC to PC+1.
- R8: The condition applies only when cond_use is high and only to call and return. The codes are 0 = zero flag clear, 1 = zero flag set, 2 = carry flag clear, 3 = carry flag set. For push, pop and restart, cond_use and the condition are ignored, and taken reads 1.
- R9: done is a one-cycle pulse in the cycle after the last machine cycle, and cycles_used equals the cycle count at that point. A start while busy is ignored. Codes 5..7 finish after 1 cycle with no access, SP unchanged and PC+1.
- R10: At most one of mem_we and mem_re is high in a cycle, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| op | input | 3 | Operation: 0 push, 1 pop, 2 call, 3 restart, 4 return |
| cond_use | input | 1 | Make call/return conditional |
| cond_code | input | 2 | Condition selector (see R8) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pair_is_flags | input | 1 | Pair is accumulator plus flag byte |
| pair_in | input | 16 | Pair value to push |
| sp_in | input | 16 | Stack pointer at start |
| pc_in | input | 16 | Address of the operation's first byte |
| target_in | input | 16 | Absolute call target |
| vec_idx | input | 3 | Restart vector index |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| taken | output | 1 | Condition met (or not conditional) |
| cycles_used | output | 3 | Machine cycles of the last operation |
| sp_out | output | 16 | Resulting stack pointer |
| pc_out | output | 16 | Resulting program counter |
| pair_out | output | 16 | Pair returned by the last pop |

## Verification
The assertions check on every cycle the properties that hold regardless of scenario. Memory accesses are exclusive and occur only while busy. Back-to-back writes descend by one address and back-to-back reads ascend by one. The low nibble of a flag byte being written is zero. done is a single pulse that follows busy, and the reported count stays within 1 to 6. Only the bench scenarios can show the outcome of each operation: the exact cycle counts for taken and untaken forms, the return addresses PC+3 and PC+1, the restart targets, the values popped into PC or the pair, and the way each condition code selects between the two paths.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int STEP_W = 3;
  localparam int VEC_SHIFT = 3;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RST  = 3'd3,
    OP_RET  = 3'd4,
    OP_X5   = 3'd5,
    OP_X6   = 3'd6,
    OP_X7   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_WR_HI = 3'd1,
    ACC_WR_LO = 3'd2,
    ACC_RD_LO = 3'd3,
    ACC_RD_HI = 3'd4
  } acc_e;

  // whether the transfer happens; only call and return are conditional
  function automatic logic op_taken(op_e op, logic cu, logic ok);
    if (op == OP_CALL || op == OP_RET) return !cu || ok;
    return 1'b1;
  endfunction

  // total machine cycles of an operation
  function automatic logic [STEP_W-1:0] op_cycles(op_e op, logic cu, logic ok);
    case (op)
      OP_PUSH: return 3'd4;
      OP_POP:  return 3'd3;
      OP_RST:  return 3'd4;
      OP_CALL: return (!cu || ok) ? 3'd6 : 3'd3;
      OP_RET:  return !cu ? 3'd4 : (ok ? 3'd5 : 3'd2);
      default: return 3'd1;
    endcase
  endfunction

  // which memory access a given step performs
  function automatic acc_e access_kind(op_e op, logic cu, logic tk,
                                       logic [STEP_W-1:0] step,
                                       logic [STEP_W-1:0] total);
    logic [STEP_W-1:0] rd0;
    rd0 = (op == OP_RET && cu) ? 3'd3 : 3'd2;
    if (!tk) return ACC_NONE;
    case (op)
      OP_PUSH, OP_CALL, OP_RST: begin
        if (step == total - 3'd1) return ACC_WR_HI;
        if (step == total)        return ACC_WR_LO;
      end
      OP_POP, OP_RET: begin
        if (step == rd0)        return ACC_RD_LO;
        if (step == rd0 + 3'd1) return ACC_RD_HI;
      end
      default: ;
    endcase
    return ACC_NONE;
  endfunction

  // flag byte: only the upper nibble is stored
  function automatic logic [DATA_W-1:0] flag_byte(logic [DATA_W-1:0] b);
    return {b[DATA_W-1:DATA_W/2], {(DATA_W/2){1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] next_sp(op_e op, logic tk, logic [ADDR_W-1:0] sp0);
    if (tk && (op == OP_PUSH || op == OP_CALL || op == OP_RST)) return sp0 - 16'd2;
    if (tk && (op == OP_POP || op == OP_RET)) return sp0 + 16'd2;
    return sp0;
  endfunction

  function automatic logic [ADDR_W-1:0] next_pc(op_e op, logic tk,
                                                 logic [ADDR_W-1:0] pc0,
                                                 logic [ADDR_W-1:0] tgt,
                                                 logic [2:0] vec,
                                                 logic [ADDR_W-1:0] popped);
    case (op)
      OP_CALL: return tk ? tgt : pc0 + 16'd3;
      OP_RST:  return ADDR_W'(vec) << VEC_SHIFT;
      OP_RET:  return tk ? popped : pc0 + 16'd1;
      default: return pc0 + 16'd1;
    endcase
  endfunction
endpackage

// File: rtl/scs_cond.sv
module scs_cond (
  input  logic [1:0] code,
  input  logic       fz,
  input  logic       fc,
  output logic       ok
);
  always_comb begin
    case (code)
      2'd0:    ok = !fz;
      2'd1:    ok = fz;
      2'd2:    ok = !fc;
      default: ok = fc;
    endcase
  end
endmodule

// File: rtl/scs_step.sv
module scs_step #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [SW-1:0] total_in,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic [SW-1:0] total,
  output logic          last
);
  assign last = busy && (step == total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      total <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      step  <= SW'(1);
      total <= total_in;
    end else if (last) begin
      busy <= 1'b0;
      step <= '0;
    end else if (busy) begin
      step <= step + SW'(1);
    end
  end
endmodule

// File: rtl/stack_call_seq.sv
module stack_call_seq
  import scs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic                cond_use,
  input  logic [1:0]          cond_code,
  input  logic                flag_z,
  input  logic                flag_c,
  input  logic                pair_is_flags,
  input  logic [ADDR_W-1:0]   pair_in,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [ADDR_W-1:0]   pc_in,
  input  logic [ADDR_W-1:0]   target_in,
  input  logic [2:0]          vec_idx,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic                busy,
  output logic                done,
  output logic                taken,
  output logic [STEP_W-1:0]   cycles_used,
  output logic [ADDR_W-1:0]   sp_out,
  output logic [ADDR_W-1:0]   pc_out,
  output logic [ADDR_W-1:0]   pair_out
);
  op_e               op_in;
  logic              cond_ok, launch, taken_now, last;
  logic [STEP_W-1:0] total_now, step, total;
  op_e               op_q;
  logic              cu_q, tk_q, fl_q;
  logic [ADDR_W-1:0] sp0_q, pc0_q, val_q, tgt_q;
  logic [2:0]        vec_q;
  logic [DATA_W-1:0] lo_q, hi_q, lo_eff, hi_eff;
  logic [ADDR_W-1:0] popped, push_val;
  acc_e              acc;
  logic              wr_flag_lo;

  assign op_in = op_e'(op);

  scs_cond u_cond (.code(cond_code), .fz(flag_z), .fc(flag_c), .ok(cond_ok));

  assign launch    = start && !busy;
  assign taken_now = op_taken(op_in, cond_use, cond_ok);
  assign total_now = op_cycles(op_in, cond_use, cond_ok);

  scs_step #(.SW(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n), .launch(launch), .total_in(total_now),
    .busy(busy), .step(step), .total(total), .last(last)
  );

  // value a push-like operation stores
  always_comb begin
    case (op_in)
      OP_CALL: push_val = pc_in + 16'd3;
      OP_RST:  push_val = pc_in + 16'd1;
      default: push_val = pair_is_flags ? {pair_in[15:8], flag_byte(pair_in[7:0])} : pair_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_PUSH;
      cu_q  <= 1'b0;
      tk_q  <= 1'b0;
      fl_q  <= 1'b0;
      sp0_q <= '0;
      pc0_q <= '0;
      val_q <= '0;
      tgt_q <= '0;
      vec_q <= '0;
    end else if (launch) begin
      op_q  <= op_in;
      cu_q  <= cond_use;
      tk_q  <= taken_now;
      fl_q  <= pair_is_flags;
      sp0_q <= sp_in;
      pc0_q <= pc_in;
      val_q <= push_val;
      tgt_q <= target_in;
      vec_q <= vec_idx;
    end
  end

  assign acc = busy ? access_kind(op_q, cu_q, tk_q, step, total) : ACC_NONE;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    case (acc)
      ACC_WR_HI: begin mem_addr = sp0_q - 16'd1; mem_wdata = val_q[15:8]; mem_we = 1'b1; end
      ACC_WR_LO: begin mem_addr = sp0_q - 16'd2; mem_wdata = val_q[7:0];  mem_we = 1'b1; end
      ACC_RD_LO: begin mem_addr = sp0_q;         mem_re = 1'b1; end
      ACC_RD_HI: begin mem_addr = sp0_q + 16'd1; mem_re = 1'b1; end
      default: ;
    endcase
  end

  // named event for the checker: flag byte leaving on the bus
  assign wr_flag_lo = (acc == ACC_WR_LO) && (op_q == OP_PUSH) && fl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (acc == ACC_RD_LO) lo_q <= mem_rdata;
      if (acc == ACC_RD_HI) hi_q <= mem_rdata;
    end
  end

  assign hi_eff = (acc == ACC_RD_HI) ? mem_rdata : hi_q;
  assign lo_eff = (op_q == OP_POP && fl_q) ? flag_byte(lo_q) : lo_q;
  assign popped = {hi_eff, lo_eff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      taken       <= 1'b0;
      cycles_used <= '0;
      sp_out      <= '0;
      pc_out      <= '0;
      pair_out    <= '0;
    end else begin
      done <= last;
      if (last) begin
        taken       <= tk_q;
        cycles_used <= total;
        sp_out      <= next_sp(op_q, tk_q, sp0_q);
        pc_out      <= next_pc(op_q, tk_q, pc0_q, tgt_q, vec_q, popped);
        if (op_q == OP_POP) pair_out <= popped;
      end
    end
  end
endmodule

// File: rtl/scs_chk.sv
module scs_chk
  import scs_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                mem_we,
  input logic                mem_re,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [STEP_W-1:0]   cycles_used,
  input logic                wr_flag_lo
);
  assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
  assert_write_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));
  assert_read_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd1));
  assert_flag_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag_lo |-> (mem_wdata[3:0] == 4'd0));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  assert_cycles_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles_used >= 3'd1 && cycles_used <= 3'd6));
endmodule

bind stack_call_seq scs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .cycles_used(cycles_used), .wr_flag_lo(wr_flag_lo)
);

// File: tb/sim_stack_call_seq.sv
`timescale 1ns/1ps
module sim_stack_call_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op_i = '0, vi = '0;
  logic cu = 1'b0, fz = 1'b0, fc = 1'b0, fl = 1'b0;
  logic [1:0] cc = '0;
  logic [15:0] pr = '0, spi = '0, pci = '0, tgi = '0;
  logic [7:0] mem_rdata, mem_wdata;
  logic [15:0] mem_addr, sp_out, pc_out, pair_out;
  logic mem_we, mem_re, busy, done, taken;
  logic [2:0] cycles_used;

  logic [7:0] ram [256];
  logic [23:0] exp_q [$];
  int checks = 0, fails = 0, acc_cnt = 0;

  always #4 clk = ~clk;

  stack_call_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .cond_use(cu),
    .cond_code(cc), .flag_z(fz), .flag_c(fc), .pair_is_flags(fl),
    .pair_in(pr), .sp_in(spi), .pc_in(pci), .target_in(tgi), .vec_idx(vi),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done), .taken(taken),
    .cycles_used(cycles_used), .sp_out(sp_out), .pc_out(pc_out), .pair_out(pair_out)
  );

  assign mem_rdata = ram[mem_addr[7:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares every write against the expected queue
  always @(negedge clk) begin
    if (mem_we || mem_re) acc_cnt++;
    if (mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R2", "write addr/data", {mem_addr, mem_wdata}, e);
      end
      ram[mem_addr[7:0]] = mem_wdata;
    end
  end

  task automatic run_op(input string req, input logic [2:0] o, input logic c_use,
                        input logic [1:0] code, input logic z, input logic c,
                        input logic f, input logic [15:0] pair, sp, pc, tg,
                        input logic [2:0] v, input bit poke, input int ecyc,
                        input logic [15:0] esp, epc, epair, input bit chk_pair,
                        input logic etk, input int eacc);
    int cnt;
    @(negedge clk);
    op_i = o; cu = c_use; cc = code; fz = z; fc = c; fl = f;
    pr = pair; spi = sp; pci = pc; tgi = tg; vi = v;
    start = 1'b1; acc_cnt = 0;
    @(posedge clk);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      start = (cnt == 0) ? poke : 1'b0;
      if (poke && cnt == 0) op_i = 3'd1;
      @(posedge clk);
      cnt++;
      if (cnt > 12) break;
    end
    start = 1'b0;
    check(done === 1'b1, req, "done seen", done, 1);
    check(cnt == ecyc, req, "measured cycles", cnt, ecyc);
    check(cycles_used == 3'(ecyc), req, "cycles_used", cycles_used, ecyc);
    check(sp_out == esp, req, "sp_out", sp_out, esp);
    check(pc_out == epc, req, "pc_out", pc_out, epc);
    check(taken == etk, req, "taken", taken, etk);
    check(acc_cnt == eacc, req, "access count", acc_cnt, eacc);
    check(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
    if (chk_pair) check(pair_out == epair, req, "pair_out", pair_out, epair);
    exp_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9", "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !mem_we && !mem_re, "R1", "idle controls", {busy, done, mem_we, mem_re}, 0);
    check(sp_out == 0 && pc_out == 0, "R1", "sp/pc zero", {sp_out, pc_out}, 0);
    check(pair_out == 0 && cycles_used == 0, "R1", "pair/cycles zero", {pair_out, 13'd0, cycles_used}, 0);

    // R2 push
    exp_q.push_back({16'h00EF, 8'h12}); exp_q.push_back({16'h00EE, 8'h34});
    run_op("R2", 3'd0, 0, 0, 0, 0, 0, 16'h1234, 16'h00F0, 16'h0200, 0, 0, 0, 4, 16'h00EE, 16'h0201, 0, 0, 1, 2);
    // R4 push of the flag pair
    exp_q.push_back({16'h00EF, 8'hA5}); exp_q.push_back({16'h00EE, 8'hF0});
    run_op("R4", 3'd0, 0, 0, 0, 0, 1, 16'hA5FF, 16'h00F0, 16'h0200, 0, 0, 0, 4, 16'h00EE, 16'h0201, 0, 0, 1, 2);
    // R3 pop
    ram[8'h80] = 8'h78; ram[8'h81] = 8'h56;
    run_op("R3", 3'd1, 0, 0, 0, 0, 0, 0, 16'h0080, 16'h0210, 0, 0, 0, 3, 16'h0082, 16'h0211, 16'h5678, 1, 1, 2);
    // R4 pop into the flag pair
    ram[8'h40] = 8'hBF; ram[8'h41] = 8'h11;
    run_op("R4", 3'd1, 0, 0, 0, 0, 1, 0, 16'h0040, 16'h0220, 0, 0, 0, 3, 16'h0042, 16'h0221, 16'h11B0, 1, 1, 2);
    // R5 unconditional call
    exp_q.push_back({16'h00FD, 8'h01}); exp_q.push_back({16'h00FC, 8'h53});
    run_op("R5", 3'd2, 0, 0, 0, 0, 0, 0, 16'h00FE, 16'h0150, 16'h4000, 0, 0, 6, 16'h00FC, 16'h4000, 0, 0, 1, 2);
    // R5/R8 call on zero-clear with Z set: untaken
    run_op("R5", 3'd2, 1, 2'd0, 1, 0, 0, 0, 16'h00FE, 16'h0150, 16'h4000, 0, 0, 3, 16'h00FE, 16'h0153, 0, 0, 0, 0);
    // R8 carry-set code with C set: taken
    exp_q.push_back({16'h009F, 8'h01}); exp_q.push_back({16'h009E, 8'h63});
    run_op("R8", 3'd2, 1, 2'd3, 0, 1, 0, 0, 16'h00A0, 16'h0160, 16'h1234, 0, 0, 6, 16'h009E, 16'h1234, 0, 0, 1, 2);
    // R8 carry-clear code with C clear: taken
    exp_q.push_back({16'h00AF, 8'h01}); exp_q.push_back({16'h00AE, 8'h73});
    run_op("R8", 3'd2, 1, 2'd2, 0, 0, 0, 0, 16'h00B0, 16'h0170, 16'h2000, 0, 0, 6, 16'h00AE, 16'h2000, 0, 0, 1, 2);
    // R8 zero-set code with Z clear: untaken
    run_op("R8", 3'd2, 1, 2'd1, 0, 1, 0, 0, 16'h00B0, 16'h0180, 16'h2000, 0, 0, 3, 16'h00B0, 16'h0183, 0, 0, 0, 0);
    // R6 restart to vector 5
    exp_q.push_back({16'h00CF, 8'h03}); exp_q.push_back({16'h00CE, 8'h01});
    run_op("R6", 3'd3, 0, 0, 0, 0, 0, 0, 16'h00D0, 16'h0300, 0, 3'd5, 0, 4, 16'h00CE, 16'h0028, 0, 0, 1, 2);
    // R6 restart to vector 7, return address crossing a byte boundary
    exp_q.push_back({16'h00CF, 8'h13}); exp_q.push_back({16'h00CE, 8'h00});
    run_op("R6", 3'd3, 1, 2'd0, 1, 0, 0, 0, 16'h00D0, 16'h12FF, 0, 3'd7, 0, 4, 16'h00CE, 16'h0038, 0, 0, 1, 2);
    // R7 unconditional return
    ram[8'h60] = 8'h34; ram[8'h61] = 8'h12;
    run_op("R7", 3'd4, 0, 0, 0, 0, 0, 0, 16'h0060, 16'h0500, 0, 0, 0, 4, 16'h0062, 16'h1234, 0, 0, 1, 2);
    // R7 conditional return taken (zero set)
    ram[8'h70] = 8'hCD; ram[8'h71] = 8'hAB;
    run_op("R7", 3'd4, 1, 2'd1, 1, 0, 0, 0, 16'h0070, 16'h0500, 0, 0, 0, 5, 16'h0072, 16'hABCD, 0, 0, 1, 2);
    // R7 conditional return untaken (zero-clear code, Z set)
    run_op("R7", 3'd4, 1, 2'd0, 1, 0, 0, 0, 16'h0070, 16'h0600, 0, 0, 0, 2, 16'h0070, 16'h0601, 0, 0, 0, 0);
    // R8 failing condition ignored for push and pop
    exp_q.push_back({16'h001F, 8'hBE}); exp_q.push_back({16'h001E, 8'hEF});
    run_op("R8", 3'd0, 1, 2'd0, 1, 0, 0, 16'hBEEF, 16'h0020, 16'h0700, 0, 0, 0, 4, 16'h001E, 16'h0701, 0, 0, 1, 2);
    ram[8'h30] = 8'h11; ram[8'h31] = 8'h22;
    run_op("R8", 3'd1, 1, 2'd3, 0, 0, 0, 0, 16'h0030, 16'h0700, 0, 0, 0, 3, 16'h0032, 16'h0701, 16'h2211, 1, 1, 2);
    // R9 start while busy is ignored
    exp_q.push_back({16'h004F, 8'h0F}); exp_q.push_back({16'h004E, 8'h0F});
    run_op("R9", 3'd0, 0, 0, 0, 0, 0, 16'h0F0F, 16'h0050, 16'h0700, 0, 0, 1, 4, 16'h004E, 16'h0701, 0, 0, 1, 2);
    // R9 unused code finishes in one cycle
    run_op("R9", 3'd7, 0, 0, 0, 0, 0, 0, 16'h0090, 16'h0800, 0, 0, 0, 1, 16'h0090, 16'h0801, 0, 0, 1, 0);
    // R10 idle after completion
    @(negedge clk);
    check(!busy && !mem_we && !mem_re, "R10", "idle bus", {busy, mem_we, mem_re}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule